// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a hardware master for the two-wire station management bus used to reach Ethernet PHYs. It divides the system clock down to make the management clock (MDC). It moves one complete management frame over the bidirectional data line and leaves the pad to an external tri-state driver: it provides an output value, an output enable and a sampled input. A host presents a request with these fields: a frame style (Clause 22 or Clause 45), a two-bit operation code, a five-bit port address, a five-bit register or device field, and sixteen write data bits. It pulses `req_valid` while the engine is idle. The engine then runs the whole frame on its own.

Each frame starts with an all-ones preamble. The start pattern, the operation and the two address fields follow. For writes and address frames the master drives the turnaround and the data. For reads the master releases the line, checks the turnaround bit the PHY returns, and shifts in sixteen data bits. Every frame ends with one released clock. If a PHY fails to pull the turnaround low, the engine clocks out whatever the PHY may still be sending, then reports all-ones data and raises an error flag. Completion is a one-cycle `done` pulse that comes with the result.

The clock timing is set in nanoseconds through parameters and is rounded up to whole system clock cycles. Bits the master drives use symmetric low and high phases. Released bits stretch the high phase so that a slow PHY has time to present its data.

Top module: `mdio_engine`

## Requirements
- R1: MDC is low for LO = ceil(MDC_HALF_NS/CLK_NS) cycles before each rising edge. It stays high for LO cycles on bits the master drives, and for RH = ceil(RD_HIGH_NS/CLK_NS) cycles on bits where the line is released.
- R2: A frame opens with 32 clocks during which the master drives the line to 1.
- R3: The two start bits after the preamble are 0,1 for a Clause 22 request (`req_c45`=0) and 0,0 for a Clause 45 request (`req_c45`=1).
- R4: The two opcode bits (`req_op[1]` first) follow the start bits, then `req_port` and then `req_dev`, each sent MSB first and driven by the master.
- R5: On a non-read frame the master drives the turnaround as 1 then 0, then `req_wdata` MSB first, for 18 driven bits after the address fields.
- R6: A frame is a read when `req_c45`=0 and `req_op`=2'b10, or when `req_c45`=1 and `req_op[1]`=1. On a read the line is released from bit 46 (counting from 0) to the end of the frame.
- R7: On a read whose turnaround bit (bit 46) is sampled as 0, the next 16 bits are sampled MSB first as MDC falls. They appear on `rd_data` with `err`=0 in the cycle `done` is high.
- R8: If the turnaround bit of a read is sampled as 1, the engine gives 32 more released clocks and then ends with `rd_data`=16'hFFFF and `err`=1. The frame is 79 clocks in total, whatever the PHY drives during those clocks.
- R9: After the 16 data bits the engine gives exactly one more clock with the line released. Write and address frames are 65 clocks long; good reads are 64 clocks long.
- R10: While the master drives the line, its value changes only in cycles where MDC is low.
- R11: `req_valid` is ignored while `busy` is high. The running frame's bits and its result are unchanged, and no extra frame follows.
- R12: `done` is high for exactly one cycle, in the cycle `busy` falls. While idle and during reset, MDC is low and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a frame (taken only when idle) |
| req_c45 | input | 1 | 1 selects the Clause 45 start pattern |
| req_op | input | 2 | Operation code sent after the start bits |
| req_port | input | 5 | Port (PHY) address |
| req_dev | input | 5 | Register number or device address |
| req_wdata | input | 16 | Data or address word for driven frames |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| err | output | 1 | Turnaround failure, valid with `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value to drive onto the data line |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Sampled data line |

## Verification
Random requests cover both frame styles and all four opcodes, so the read/write split of R6 is tested on every opcode. Random port, device, write and read words check bit order in every field. Directed all-zero and all-ones words separate a stuck serial path from correct shifting. Reads with a high turnaround bit, where the PHY drives zeros during the drain, show whether the error path really ignores the drained bits. A request injected in the middle of a frame shows whether anything is taken while busy. Per-bit timing of the MDC phases separates driven bits from released bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_PRE,
        FS_HDR,
        FS_TXD,
        FS_TA_RX,
        FS_RXD,
        FS_DRAIN,
        FS_TRAIL
    } frame_state_e;

    typedef struct packed {
        logic        c45;
        logic [1:0]  op;
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] wdata;
    } mgmt_req_t;

    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int TXD_BITS   = 18;
    localparam int RXD_BITS   = 16;
    localparam int DRAIN_BITS = 32;
    localparam int LEFT_W     = 6;

    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic logic is_read_op(input logic c45, input logic [1:0] op);
        return c45 ? op[1] : (op == 2'b10);
    endfunction

    // start pair, opcode, port, dev, turnaround 1/0, data word
    function automatic logic [31:0] tx_image(input mgmt_req_t r);
        return {1'b0, ~r.c45, r.op, r.port, r.dev, 2'b10, r.wdata};
    endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int LO_CYC    = 63,
    parameter int RD_HI_CYC = 88
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic long_hi,
    output logic mdc,
    output logic bit_end
);
    localparam int MAXC = (RD_HI_CYC > LO_CYC) ? RD_HI_CYC : LO_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          hi;
    logic [CW-1:0] hi_last;

    assign hi_last = long_hi ? CW'(RD_HI_CYC - 1) : CW'(LO_CYC - 1);
    assign bit_end = run && hi && (cnt == hi_last);
    assign mdc     = hi;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (!hi) begin
            if (cnt == CW'(LO_CYC - 1)) begin
                hi  <= 1'b1;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (bit_end) begin
            hi  <= 1'b0;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mgmt_req_t   req,
    input  logic        bit_end,
    input  logic        mdio_i,
    output logic        run,
    output logic        long_hi,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        err
);
    frame_state_e      state;
    logic [LEFT_W-1:0] left;
    logic [31:0]       txsr;
    logic [15:0]       rxsr;
    logic              rd;

    always_comb begin
        mdio_oe = (state == FS_PRE) || (state == FS_HDR) || (state == FS_TXD);
        if (state == FS_PRE)
            mdio_o = 1'b1;
        else if (state == FS_HDR || state == FS_TXD)
            mdio_o = txsr[31];
        else
            mdio_o = 1'b0;
    end

    assign run     = (state != FS_IDLE);
    assign long_hi = !mdio_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FS_IDLE;
            left    <= '0;
            txsr    <= '0;
            rxsr    <= '0;
            rd      <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == FS_IDLE) begin
                if (start) begin
                    state <= FS_PRE;
                    left  <= LEFT_W'(PRE_BITS - 1);
                    txsr  <= tx_image(req);
                    rd    <= is_read_op(req.c45, req.op);
                end
            end else if (bit_end) begin
                unique case (state)
                    FS_PRE: begin
                        if (left == '0) begin
                            state <= FS_HDR;
                            left  <= LEFT_W'(HDR_BITS - 1);
                        end else begin
                            left <= left - 1'b1;
                        end
                    end
                    FS_HDR: begin
                        txsr <= {txsr[30:0], 1'b0};
                        if (left == '0) begin
                            if (rd) begin
                                state <= FS_TA_RX;
                                left  <= '0;
                            end else begin
                                state <= FS_TXD;
                                left  <= LEFT_W'(TXD_BITS - 1);
                            end
                        end else begin
                            left <= left - 1'b1;
                        end
                    end
                    FS_TXD: begin
                        txsr <= {txsr[30:0], 1'b0};
                        if (left == '0) state <= FS_TRAIL;
                        else            left  <= left - 1'b1;
                    end
                    FS_TA_RX: begin
                        if (!mdio_i) begin
                            state <= FS_RXD;
                            left  <= LEFT_W'(RXD_BITS - 1);
                        end else begin
                            state <= FS_DRAIN;
                            left  <= LEFT_W'(DRAIN_BITS - 1);
                        end
                    end
                    FS_RXD: begin
                        rxsr <= {rxsr[14:0], mdio_i};
                        if (left == '0) state <= FS_TRAIL;
                        else            left  <= left - 1'b1;
                    end
                    FS_DRAIN: begin
                        if (left == '0) begin
                            state   <= FS_IDLE;
                            done    <= 1'b1;
                            rd_data <= 16'hFFFF;
                            err     <= 1'b1;
                        end else begin
                            left <= left - 1'b1;
                        end
                    end
                    FS_TRAIL: begin
                        state <= FS_IDLE;
                        done  <= 1'b1;
                        err   <= 1'b0;
                        if (rd) rd_data <= rxsr;
                    end
                    default: state <= FS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int CLK_NS      = 4,
    parameter int MDC_HALF_NS = 250,
    parameter int RD_HIGH_NS  = 350
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_c45,
    input  logic [1:0]  req_op,
    input  logic [4:0]  req_port,
    input  logic [4:0]  req_dev,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int LO_CYC    = ns_to_cycles(MDC_HALF_NS, CLK_NS);
    localparam int RD_HI_CYC = ns_to_cycles(RD_HIGH_NS, CLK_NS);

    mgmt_req_t req;
    logic      run, long_hi, bit_end;

    assign req  = '{c45: req_c45, op: req_op, port: req_port, dev: req_dev, wdata: req_wdata};
    assign busy = run;

    mdio_phase_timer #(
        .LO_CYC    (LO_CYC),
        .RD_HI_CYC (RD_HI_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .long_hi (long_hi),
        .mdc     (mdc),
        .bit_end (bit_end)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (req_valid),
        .req     (req),
        .bit_end (bit_end),
        .mdio_i  (mdio_i),
        .run     (run),
        .long_hi (long_hi),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rd_data (rd_data),
        .err     (err)
    );
endmodule

// File: rtl/mdio_engine_chk.sv
module mdio_engine_chk #(
    parameter int HALF_CYC = 63
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [15:0] rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)      hi_run <= '0;
        else if (mdc) hi_run <= hi_run + 1'b1;
        else          hi_run <= '0;
    end

    AST_MDC_HIGH_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |-> (hi_run >= 16'(HALF_CYC))); // R1

    AST_PRE_DRIVEN_ONE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mdio_oe && mdio_o)); // R2

    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (rd_data == 16'hFFFF)); // R8

    AST_TX_CHANGE_LOW: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc); // R10

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12

    AST_DONE_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe)); // R12
endmodule

bind mdio_engine mdio_engine_chk #(.HALF_CYC(LO_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .rd_data (rd_data),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_engine.sv
`timescale 1ns/1ps
module tb_mdio_engine;
    localparam int EXP_LO = 3;   // ceil(12/4)
    localparam int EXP_RH = 5;   // ceil(20/4)
    localparam int MAXB   = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_c45 = 1'b0;
    logic [1:0]  req_op = '0;
    logic [4:0]  req_port = '0, req_dev = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic phy_val = 1'b1;
    logic mdio_i;

    assign mdio_i = mdio_oe ? mdio_o : phy_val;

    always #2 clk = ~clk;

    mdio_engine #(.CLK_NS(4), .MDC_HALF_NS(12), .RD_HIGH_NS(20)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_c45(req_c45),
        .req_op(req_op), .req_port(req_port), .req_dev(req_dev),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .err(err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    int nchk = 0, nfail = 0, cyc = 0;

    // frame under test
    logic f_c45; logic [1:0] f_op; logic [4:0] f_pa, f_ra;
    logic [15:0] f_wd, f_rd; logic f_bad;

    // monitor state
    int bitidx = 0, locnt = 0, hicnt = 0, ndone = 0;
    logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0, hi_change = 1'b0;
    logic cap_oe [MAXB]; logic cap_o [MAXB];
    int   lo_len [MAXB]; int hi_len [MAXB];

    function automatic logic bench_is_read(logic c45, logic [1:0] op);
        if (c45) return op == 2'b11 || op == 2'b10;
        return op == 2'b10;
    endfunction

    function automatic int exp_len();
        if (!bench_is_read(f_c45, f_op)) return 65;
        return f_bad ? 79 : 64;
    endfunction

    function automatic logic [1:0] exp_bit(int k);
        logic [13:0] hdr;
        hdr = {1'b0, !f_c45, f_op, f_pa, f_ra};
        if (k < 32) return 2'b11;
        if (k < 46) return {1'b1, hdr[13-(k-32)]};
        if (bench_is_read(f_c45, f_op)) return 2'b00;
        if (k == 46) return 2'b11;
        if (k == 47) return 2'b10;
        if (k < 64) return {1'b1, f_wd[15-(k-48)]};
        return 2'b00;
    endfunction

    function automatic logic phy_bit(int k);
        if (!bench_is_read(f_c45, f_op)) return 1'b1;
        if (k == 46) return f_bad;
        if (f_bad) return 1'b0;               // drained bits pulled low
        if (k >= 47 && k < 63) return f_rd[15-(k-47)];
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (done) ndone <= ndone + 1;
        if (busy && mdc && mdio_oe && prev_oe && (mdio_o != prev_o)) hi_change <= 1'b1;
        prev_o  <= mdio_o;
        prev_oe <= mdio_oe;
        if (mdc && !prev_mdc) begin
            if (bitidx < MAXB) begin
                cap_oe[bitidx] <= mdio_oe;
                cap_o[bitidx]  <= mdio_o;
                lo_len[bitidx] <= locnt;
            end
            phy_val <= phy_bit(bitidx);
            bitidx  <= bitidx + 1;
            hicnt   <= 1;
        end else if (!mdc && prev_mdc) begin
            if (bitidx >= 1 && bitidx <= MAXB) hi_len[bitidx-1] <= hicnt;
            locnt <= busy ? 1 : 0;
        end else if (mdc) begin
            hicnt <= hicnt + 1;
        end else if (busy) begin
            locnt <= locnt + 1;
        end
        prev_mdc <= mdc;
    end

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic run_frame(input logic c45, input logic [1:0] op, input logic [4:0] pa,
                             input logic [4:0] ra, input logic [15:0] wd, input logic [15:0] rdv,
                             input logic bad, input logic inject);
        int n, len, errs, terr, d0;
        logic [1:0] e;
        f_c45 = c45; f_op = op; f_pa = pa; f_ra = ra; f_wd = wd; f_rd = rdv; f_bad = bad;
        @(negedge clk);
        bitidx = 0; locnt = 0; hicnt = 0; hi_change = 1'b0; phy_val = 1'b1;
        d0 = ndone;
        req_c45 = c45; req_op = op; req_port = pa; req_dev = ra; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++;
            if (inject && n == 40) begin
                req_c45 = ~c45; req_op = ~op; req_port = ~pa; req_dev = ~ra; req_wdata = ~wd;
                req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        check(done == 1'b1, "R12", "done seen", done, 1);
        len = exp_len();
        if (bench_is_read(c45, op)) begin
            if (bad) begin
                check(rd_data == 16'hFFFF && err, "R8", "fail result", {err, rd_data}, {1'b1, 16'hFFFF});
            end else begin
                check(rd_data == rdv && !err, "R7", "read result", {err, rd_data}, {1'b0, rdv});
            end
        end else begin
            check(!err, "R5", "write err flag", err, 0);
        end
        @(negedge clk);
        check(!busy && !done, "R12", "one-cycle done, idle after", {busy, done}, 0);
        repeat (3 * EXP_RH) @(negedge clk);
        check(bitidx == len, bad ? "R8" : "R9", "mdc clocks per frame", bitidx, len);
        check(ndone - d0 == 1, "R11", "done pulses per request", ndone - d0, 1);
        // field-by-field bit comparison
        errs = 0;
        for (int k = 0; k < 32; k++) begin
            e = exp_bit(k);
            if (cap_oe[k] != e[1] || (e[1] && cap_o[k] != e[0])) errs++;
        end
        check(errs == 0, "R2", "preamble bits wrong", errs, 0);
        errs = 0;
        for (int k = 32; k < 34; k++) begin
            e = exp_bit(k);
            if (cap_oe[k] != e[1] || cap_o[k] != e[0]) errs++;
        end
        check(errs == 0, "R3", "start bits wrong", {cap_o[32], cap_o[33]}, {exp_bit(32), exp_bit(33)});
        errs = 0;
        for (int k = 34; k < 46; k++) begin
            e = exp_bit(k);
            if (cap_oe[k] != e[1] || cap_o[k] != e[0]) errs++;
        end
        check(errs == 0, "R4", "op/port/dev bits wrong", errs, 0);
        errs = 0;
        for (int k = 46; k < len && k < MAXB; k++) begin
            e = exp_bit(k);
            if (cap_oe[k] != e[1] || (e[1] && cap_o[k] != e[0])) errs++;
        end
        check(errs == 0, bench_is_read(c45, op) ? "R6" : "R5", "tail bits wrong", errs, 0);
        terr = 0;
        for (int k = 0; k < len && k < MAXB; k++) begin
            e = exp_bit(k);
            if (lo_len[k] != EXP_LO) terr++;
            if (hi_len[k] != (e[1] ? EXP_LO : EXP_RH)) terr++;
        end
        check(terr == 0, "R1", "mdc phase lengths wrong", terr, 0);
        check(!hi_change, "R10", "driven bit changed while mdc high", hi_change, 0);
    endtask

    initial begin
        void'($urandom(32'd20241));
        repeat (4) @(negedge clk);
        check(!busy && !mdc && !mdio_oe && !done, "R12", "reset state",
              {busy, mdc, mdio_oe, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !mdc && !mdio_oe, "R12", "idle after reset", {busy, mdc, mdio_oe}, 0);
        // directed corners
        run_frame(1'b0, 2'b10, 5'h01, 5'h02, 16'h0000, 16'hA55A, 1'b0, 1'b0); // R7 c22 read
        run_frame(1'b0, 2'b01, 5'h1F, 5'h00, 16'hFFFF, 16'h0000, 1'b0, 1'b0); // R5 c22 write
        run_frame(1'b0, 2'b01, 5'h00, 5'h1F, 16'h0000, 16'h0000, 1'b0, 1'b0); // R5 zeros
        run_frame(1'b1, 2'b00, 5'h15, 5'h0A, 16'h1234, 16'h0000, 1'b0, 1'b0); // R3 c45 address
        run_frame(1'b1, 2'b11, 5'h03, 5'h07, 16'h0000, 16'hFFFF, 1'b0, 1'b0); // R6 c45 read
        run_frame(1'b1, 2'b11, 5'h03, 5'h07, 16'h0000, 16'h1357, 1'b1, 1'b0); // R8 bad TA
        run_frame(1'b0, 2'b10, 5'h0C, 5'h11, 16'h0000, 16'h0001, 1'b1, 1'b0); // R8 c22
        run_frame(1'b0, 2'b11, 5'h0C, 5'h11, 16'hBEEF, 16'h0000, 1'b0, 1'b0); // R6 c22 op 11 not read
        run_frame(1'b0, 2'b01, 5'h09, 5'h05, 16'hC3A5, 16'h0000, 1'b0, 1'b1); // R11 inject
        run_frame(1'b0, 2'b10, 5'h09, 5'h05, 16'h0000, 16'h8001, 1'b0, 1'b1); // R11 inject read
        // constrained random
        for (int i = 0; i < 30; i++) begin
            run_frame(1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom),
                      16'($urandom), 16'($urandom), ($urandom % 6) == 0, ($urandom % 5) == 0);
        end
        finish_run();
    end

    initial begin
        wait (cyc > 150000);
        check(1'b0, "R12", "watchdog expired", cyc, 150000);
        finish_run();
    end
endmodule